// File: doc/BRIEF.md
# Periodic Interval and Watchdog System Timer

This block is a system timer peripheral that sits on a word-wide register bus. It holds three mode registers. The first drives a periodic interval down-counter. The second reloads a watchdog counter. The third loads a real-time prescaler counter. Every counter moves only on a single-cycle `tick_en` strobe, so the rate is set by whoever generates that strobe and not by the bus clock.

When the interval counter expires on a tick, the interval flag in the status register is set and the counter reloads from its mode value. If the matching bit in the interrupt mask is also set, a single system-interrupt request `sys_irq` is raised toward the interrupt controller. That request stays high until the controller pulses `irq_ack`.

Software works with the mask through two command registers, one that sets bits and one that clears them, and can read the mask back. Reading the status register clears it. Watchdog reset generation, alarm matching and real-time counting are not part of the block. The watchdog mode, real-time mode and alarm values are only stored, and the counters are only reloaded.

Top module: `sys_tick_timer`

## Requirements
- R1: After an active-low reset, every readable register reads 0 and `sys_irq` is low. Reads from offsets 0 (control), 5, 6 and 12..15 always return 0.
- R2: The interval counter (read-only at offset 9) decrements by one on each `tick_en` only while the interval mode (offset 1) is nonzero. Otherwise it holds.
- R3: On a tick where the interval mode is nonzero and the counter is 0, status bit 0 is set and the counter reloads from the interval mode value.
- R4: An interval expiry sets `sys_irq` on the next clock only when mask bit 0 is set.
- R5: A write to offset 1 stores the value and loads it into the interval counter on that clock. A tick in the same cycle has no other effect.
- R6: A write to offset 2 stores the watchdog mode and loads the watchdog counter (read at offset 10). A write to offset 0 reloads the watchdog counter from the stored watchdog mode.
- R7: A write to offset 3 stores the real-time mode and loads the prescaler counter (read at offset 11).
- R8: A read of the status register (offset 4, 4 bits wide) returns its current value, and all bits are 0 on the next clock. An expiry in the same cycle as the read leaves bit 0 set.
- R9: A write to offset 5 ORs `wdata[3:0]` into the 4-bit mask. A write to offset 6 clears the mask bits that are 1 in `wdata[3:0]`. The mask reads back at offset 7.
- R10: A write to offset 5 that leaves any mask bit set raises `sys_irq` on the next clock.
- R11: `sys_irq` holds until an `irq_ack` pulse clears it. If a new request arrives in the same cycle as the acknowledge, the request wins.
- R12: The alarm register at offset 8 stores the written word and reads it back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Single-cycle counter advance strobe |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (read side effects) |
| addr | input | AW (4) | Word offset of the register |
| wdata | input | DW (32) | Write data |
| rdata | output | DW (32) | Read data, combinational from `addr` |
| irq_ack | input | 1 | Clears the pending system-interrupt request |
| sys_irq | output | 1 | System-interrupt request |

## Verification
A wrong interval count shows up at the counter readback on the very next tick. It also shows up as a status flag or an interrupt that arrives a tick early or late, one full mode period after the error. A corrupted mask or pending request appears at `sys_irq` on the clock after the write, expiry or acknowledge that should have changed it. A status clear that fails, or one that drops a coincident expiry, is visible at the next status read. Every cycle, the bench compares `sys_irq` and every read against a bench model, so any wrong state is reported within one cycle of reaching the ports.

// File: rtl/sys_tick_timer.sv
module sys_tick_timer #(
  parameter int DW   = 32,
  parameter int AW   = 4,
  parameter int NIRQ = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          irq_ack,
  output logic          sys_irq
);
  localparam logic [AW-1:0] A_CTRL  = AW'(0);
  localparam logic [AW-1:0] A_PIT   = AW'(1);
  localparam logic [AW-1:0] A_WDM   = AW'(2);
  localparam logic [AW-1:0] A_RTM   = AW'(3);
  localparam logic [AW-1:0] A_STAT  = AW'(4);
  localparam logic [AW-1:0] A_ISET  = AW'(5);
  localparam logic [AW-1:0] A_ICLR  = AW'(6);
  localparam logic [AW-1:0] A_MASK  = AW'(7);
  localparam logic [AW-1:0] A_ALRM  = AW'(8);
  localparam logic [AW-1:0] A_PCNT  = AW'(9);
  localparam logic [AW-1:0] A_WCNT  = AW'(10);
  localparam logic [AW-1:0] A_RCNT  = AW'(11);
  localparam int            PAD     = DW - NIRQ;

  logic [DW-1:0]   pit_mode, pit_cnt, wd_mode, wd_cnt, rt_mode, rt_cnt, alarm;
  logic [NIRQ-1:0] status, mask, mask_nxt;

  wire wr_pit  = wr_en && addr == A_PIT;
  wire wr_iset = wr_en && addr == A_ISET;
  wire wr_iclr = wr_en && addr == A_ICLR;
  wire rd_stat = rd_en && addr == A_STAT;
  wire pit_on  = pit_mode != '0;
  wire expire  = tick_en && !wr_pit && pit_on && pit_cnt == '0;

  assign mask_nxt = wr_iset ? (mask | wdata[NIRQ-1:0])
                  : wr_iclr ? (mask & ~wdata[NIRQ-1:0]) : mask;

  wire irq_set = (expire && mask[0]) || (wr_iset && mask_nxt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pit_mode <= '0;
      pit_cnt  <= '0;
    end else if (wr_pit) begin
      pit_mode <= wdata;
      pit_cnt  <= wdata;
    end else if (tick_en && pit_on) begin
      pit_cnt  <= (pit_cnt == '0) ? pit_mode : pit_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_mode <= '0;
      wd_cnt  <= '0;
      rt_mode <= '0;
      rt_cnt  <= '0;
      alarm   <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL: wd_cnt <= wd_mode;
        A_WDM:  begin wd_mode <= wdata; wd_cnt <= wdata; end
        A_RTM:  begin rt_mode <= wdata; rt_cnt <= wdata; end
        A_ALRM: alarm <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status  <= '0;
      mask    <= '0;
      sys_irq <= 1'b0;
    end else begin
      status  <= (rd_stat ? '0 : status) | {{(NIRQ-1){1'b0}}, expire};
      mask    <= mask_nxt;
      sys_irq <= irq_set | (sys_irq & ~irq_ack);
    end
  end

  always_comb begin
    case (addr)
      A_PIT:   rdata = pit_mode;
      A_WDM:   rdata = wd_mode;
      A_RTM:   rdata = rt_mode;
      A_STAT:  rdata = {{PAD{1'b0}}, status};
      A_MASK:  rdata = {{PAD{1'b0}}, mask};
      A_ALRM:  rdata = alarm;
      A_PCNT:  rdata = pit_cnt;
      A_WCNT:  rdata = wd_cnt;
      A_RCNT:  rdata = rt_cnt;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/sys_tick_timer_chk.sv
module sys_tick_timer_chk #(
  parameter int DW   = 32,
  parameter int AW   = 4,
  parameter int NIRQ = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick_en,
  input logic            wr_en,
  input logic            rd_en,
  input logic [AW-1:0]   addr,
  input logic [DW-1:0]   wdata,
  input logic            irq_ack,
  input logic            sys_irq,
  input logic [DW-1:0]   pit_mode,
  input logic [DW-1:0]   pit_cnt,
  input logic [NIRQ-1:0] status,
  input logic [NIRQ-1:0] mask
);
  wire c_wr_pit  = wr_en && addr == AW'(1);
  wire c_rd_stat = rd_en && addr == AW'(4);
  wire c_wr_iset = wr_en && addr == AW'(5);
  wire c_wr_iclr = wr_en && addr == AW'(6);
  wire c_run     = tick_en && !c_wr_pit && pit_mode != '0;
  wire c_exp     = c_run && pit_cnt == '0;
  wire c_req     = (c_exp && mask[0]) || (c_wr_iset && (mask | wdata[NIRQ-1:0]) != '0);

  p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (c_run && pit_cnt != '0) |=> pit_cnt == $past(pit_cnt) - 1'b1);

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !c_wr_pit) |=> $stable(pit_cnt));

  p_expire_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    c_exp |=> (status[0] && pit_cnt == $past(pit_mode)));

  p_load_now_r5: assert property (@(posedge clk) disable iff (!rst_n)
    c_wr_pit |=> (pit_cnt == $past(wdata) && pit_mode == $past(wdata)));

  p_stat_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd_stat && !c_exp) |=> status == '0);

  p_mask_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    c_wr_iclr |=> (mask & $past(wdata[NIRQ-1:0])) == '0);

  p_irq_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_irq) |-> $past(c_req));

  p_irq_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !c_req) |=> !sys_irq);
endmodule

bind sys_tick_timer sys_tick_timer_chk #(.DW(DW), .AW(AW), .NIRQ(NIRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .wdata(wdata), .irq_ack(irq_ack), .sys_irq(sys_irq),
  .pit_mode(pit_mode), .pit_cnt(pit_cnt), .status(status), .mask(mask)
);

// File: tb/sys_tick_timer_tb.sv
module sys_tick_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0, irq_ack = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sys_irq;
  int          checks = 0, errors = 0, cyc = 0;

  sys_tick_timer u_dut (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq_ack(irq_ack),
    .sys_irq(sys_irq));

  always #10 clk = ~clk;

  logic [31:0] m_pm = 0, m_pc = 0, m_wm = 0, m_wc = 0, m_rm = 0, m_rc = 0, m_al = 0;
  logic [3:0]  m_sr = 0, m_mk = 0;
  logic        m_irq = 0;
  string       irq_tag = "R1";

  function automatic logic [31:0] exp_rd(input logic [3:0] a);
    case (a)
      4'd1: return m_pm;   4'd2: return m_wm;   4'd3: return m_rm;
      4'd4: return {28'd0, m_sr};  4'd7: return {28'd0, m_mk};
      4'd8: return m_al;   4'd9: return m_pc;   4'd10: return m_wc;
      4'd11: return m_rc;  default: return 32'd0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [3:0] a);
    case (a)
      4'd1: return "R5";  4'd2, 4'd10: return "R6";  4'd3, 4'd11: return "R7";
      4'd4: return (m_sr[0] ? "R3" : "R8");  4'd7: return "R9";
      4'd8: return "R12"; 4'd9: return "R2";  default: return "R1";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit tk, input bit wr, input bit rd, input logic [3:0] a,
                      input logic [31:0] d, input bit ack);
    bit exp_f, pw, iset;
    logic [3:0] mk_n;
    tick_en = tk; wr_en = wr; rd_en = rd; addr = a; wdata = d; irq_ack = ack;
    #1;
    if (rd) chk(rdata === exp_rd(a), rd_tag(a), rdata, exp_rd(a));
    chk(sys_irq === m_irq, irq_tag, {31'd0, sys_irq}, {31'd0, m_irq});
    @(posedge clk);
    pw    = wr && a == 4'd1;
    iset  = wr && a == 4'd5;
    exp_f = tk && !pw && m_pm != 0 && m_pc == 0;
    mk_n  = iset ? (m_mk | d[3:0]) : (wr && a == 4'd6) ? (m_mk & ~d[3:0]) : m_mk;
    irq_tag = (exp_f && m_mk[0]) ? "R4" : (iset && mk_n != 0) ? "R10" : "R11";
    m_irq = (exp_f && m_mk[0]) || (iset && mk_n != 0) || (m_irq && !ack);
    m_sr  = ((rd && a == 4'd4) ? 4'd0 : m_sr) | {3'd0, exp_f};
    m_mk  = mk_n;
    if (pw) begin m_pm = d; m_pc = d; end
    else if (tk && m_pm != 0) m_pc = (m_pc == 0) ? m_pm : m_pc - 1;
    if (wr && a == 4'd0) m_wc = m_wm;
    if (wr && a == 4'd2) begin m_wm = d; m_wc = d; end
    if (wr && a == 4'd3) begin m_rm = d; m_rc = d; end
    if (wr && a == 4'd8) m_al = d;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5a17));
    #5;
    chk(sys_irq === 1'b0, "R1", {31'd0, sys_irq}, 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 16; i++) step(0, 0, 1, 4'(i), 0, 0);
    step(1, 1, 0, 4'd1, 32'd3, 0);
    step(0, 0, 1, 4'd9, 0, 0);
    step(1, 0, 1, 4'd9, 0, 0);
    step(0, 1, 0, 4'd5, 32'h1, 0);
    step(0, 0, 1, 4'd7, 0, 1);
    step(1, 0, 0, 4'd0, 0, 0);
    step(1, 0, 0, 4'd0, 0, 0);
    step(1, 0, 1, 4'd4, 0, 0);
    step(0, 0, 1, 4'd4, 0, 0);
    step(0, 0, 1, 4'd4, 0, 0);
    step(0, 1, 0, 4'd5, 32'h4, 1);
    step(0, 1, 0, 4'd6, 32'h5, 1);
    step(0, 0, 1, 4'd7, 0, 0);
    step(1, 1, 0, 4'd1, 32'd0, 0);
    step(1, 0, 1, 4'd9, 0, 0);
    step(0, 1, 0, 4'd2, 32'hdead_0010, 0);
    step(0, 0, 1, 4'd10, 0, 0);
    step(0, 1, 0, 4'd2, 32'h0000_0077, 0);
    step(0, 1, 0, 4'd10, 32'h1234, 0);
    step(0, 1, 0, 4'd0, 32'hffff, 0);
    step(0, 0, 1, 4'd10, 0, 0);
    step(0, 1, 0, 4'd3, 32'hcafe_0003, 0);
    step(0, 0, 1, 4'd11, 0, 0);
    step(0, 1, 0, 4'd8, 32'h8765_4321, 0);
    step(0, 0, 1, 4'd8, 0, 0);
    for (int i = 0; i < 4000; i++) begin
      int unsigned op = $urandom % 16;
      logic [31:0] d = $urandom;
      bit w = ($urandom % 4) == 0;
      if (op == 1) d = $urandom % 6;
      if (op == 5 || op == 6) d = $urandom % 16;
      step($urandom % 2, w, !w, 4'(op), d, ($urandom % 8) == 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule